// File: doc/BRIEF.md
# Collision-Line Heartbeat Generator

This block produces the signal-quality-error heartbeat that a port acting as the PHY side of a media-independent link shows to an attached MAC after each of its transmissions. Time is measured in bit times, counted from a one-cycle bit-time tick supplied by the surrounding clocking logic. When the MAC lowers its transmit enable, the block waits a fixed number of bit times and then raises a heartbeat pulse for a fixed number of bit times. The surrounding logic ORs this pulse into the collision output seen by the MAC.

The heartbeat exists only on a 10 Mb/s half-duplex link. A control bit suppresses it entirely. Any new transmission or any change of link mode that arrives while a heartbeat is pending or showing abandons that heartbeat. Delay and width are elaboration parameters in bit times.

Top module: `sqe_heartbeat_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle and `sqe_pulse` is low after that edge, even if a pulse was showing.
- R2: On a 10 Mb/s half-duplex link (`speed_10`=1, `full_duplex`=0) with `sqe_off`=0, the first clock edge that samples `tx_en` low after a transmission starts the delay. `sqe_pulse` rises after the edge that carries the DELAY_BITS-th `bit_tick` counted from the next edge onward.
- R3: Once raised, `sqe_pulse` stays high through exactly WIDTH_BITS `bit_tick` edges and falls after the edge carrying the last of them.
- R4: Only edges with `bit_tick` high advance the delay and width counts. Any spacing of ticks gives the same delay and width counted in ticks.
- R5: With `speed_10`=0, no heartbeat follows a transmission.
- R6: With `full_duplex`=1, no heartbeat follows a transmission.
- R7: With `sqe_off`=1, no heartbeat follows a transmission.
- R8: If `tx_en` is sampled high during the delay or the pulse, the pending heartbeat is cancelled: `sqe_pulse` is low after that edge. A later end of transmission starts a full new delay.
- R9: If the link stops being 10 Mb/s half duplex with `sqe_off`=0 during the delay or the pulse, the heartbeat is cancelled at the next edge. It does not resume when the mode is restored.
- R10: DELAY_BITS (default 10) must lie in 6..16 and WIDTH_BITS (default 10) in 5..15. Both ends of the ranges give exact timing.
- R11: Without a preceding transmission, `sqe_pulse` stays low however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| tx_en | input | 1 | Transmit enable from the attached MAC |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| speed_10 | input | 1 | 1 = link runs at 10 Mb/s |
| sqe_off | input | 1 | 1 = heartbeat suppressed |
| sqe_pulse | output | 1 | Heartbeat, to be ORed into the collision output |

## Verification
The bench builds two instances side by side. One uses the lowest legal delay and width (6 and 5). It carries the table of mode and tick-spacing cases and the cancellation tests, so each heartbeat takes only a few dozen cycles. The other uses the highest legal values (16 and 15), which brings the upper end of the counter and the widest compare values within reach. Tick spacings of one to four cycles show that the timing depends on ticks and not on cycles.

// File: rtl/sqe_pkg.sv
// Shared types for the heartbeat generator.
package sqe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TX    = 2'd1,
        ST_DELAY = 2'd2,
        ST_PULSE = 2'd3
    } sqe_state_e;
endpackage

// File: rtl/sqe_mode_gate.sv
// Decides whether the link mode allows a heartbeat at all.
// Assumes the mode inputs are already synchronous to clk.
module sqe_mode_gate (
    input  logic speed_10,
    input  logic full_duplex,
    input  logic sqe_off,
    output logic allow
);
    // Heartbeat only on 10 Mb/s, half duplex, not suppressed.
    always_comb allow = speed_10 && !full_duplex && !sqe_off;
endmodule

// File: rtl/sqe_bit_counter.sv
// Bit-time counter: counts ticks from zero and flags the tick that reaches
// the given limit. Assumes clr is held while the counter is not in use.
module sqe_bit_counter #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // Count ticks; clear on request or at reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (tick)     cnt_q <= cnt_q + 1'b1;
    end

    // Terminal flag on the tick that reaches the limit.
    always_comb done = tick && (cnt_q == limit);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> cnt_q <= limit) else $error("count beyond limit"); // R3
endmodule

// File: rtl/sqe_fsm.sv
// Sequencer: follows a transmission, runs the delay on its end, then shows
// the pulse. Cancels on a new transmission or a mode change.
// Assumes done comes from a counter cleared whenever clr is high.
module sqe_fsm
    import sqe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic allow,
    input  logic done,
    output logic clr,
    output logic sel_width,
    output logic pulse
);
    sqe_state_e state_q, state_d;

    // Next state from transmission, mode and count.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (tx_en) state_d = ST_TX;
            ST_TX:    if (!tx_en) state_d = allow ? ST_DELAY : ST_IDLE;
            ST_DELAY: if (tx_en || !allow) state_d = ST_IDLE;
                      else if (done)       state_d = ST_PULSE;
            ST_PULSE: if (tx_en || !allow || done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counter control and outputs decoded from the state.
    always_comb begin
        clr       = !(state_q == ST_DELAY || state_q == ST_PULSE) || (state_d != state_q);
        sel_width = (state_q == ST_PULSE);
        pulse     = (state_q == ST_PULSE);
    end

    AST_DELAY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_DELAY) |-> $past(state_q == ST_TX && !tx_en && allow))
        else $error("delay without end of transmission"); // R2
    AST_PULSE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(state_q == ST_DELAY && done))
        else $error("pulse without full delay"); // R2
    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && done) |=> !pulse) else $error("pulse overran"); // R3
    AST_DELAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY && !done && !tx_en && allow) |=> state_q == ST_DELAY)
        else $error("delay moved without tick"); // R4
    AST_TX_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DELAY || pulse) && tx_en) |=> (!pulse && state_q == ST_IDLE))
        else $error("transmission did not cancel"); // R8
    AST_MODE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DELAY || pulse) && !allow) |=> state_q == ST_IDLE)
        else $error("mode change did not cancel"); // R9
endmodule

// File: rtl/sqe_heartbeat_gen.sv
// Heartbeat generator top: mode gate, sequencer and bit-time counter.
// Assumes bit_tick is a one-cycle strobe and all inputs are synchronous.
module sqe_heartbeat_gen #(
    parameter int DELAY_BITS = 10,
    parameter int WIDTH_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic tx_en,
    input  logic full_duplex,
    input  logic speed_10,
    input  logic sqe_off,
    output logic sqe_pulse
);
    localparam int MAXB = (DELAY_BITS > WIDTH_BITS) ? DELAY_BITS : WIDTH_BITS;
    localparam int CW   = $clog2(MAXB + 1);
    localparam logic [CW-1:0] LIM_DELAY = CW'(DELAY_BITS - 1);
    localparam logic [CW-1:0] LIM_WIDTH = CW'(WIDTH_BITS - 1);

    logic allow, done, clr, sel_width;
    logic [CW-1:0] limit;

    initial begin
        AST_PARAM_RANGE: assert (DELAY_BITS >= 6 && DELAY_BITS <= 16 &&
                                 WIDTH_BITS >= 5 && WIDTH_BITS <= 15)
            else $error("delay or width out of range"); // R10
    end

    sqe_mode_gate u_gate (
        .speed_10    (speed_10),
        .full_duplex (full_duplex),
        .sqe_off     (sqe_off),
        .allow       (allow)
    );

    sqe_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .allow     (allow),
        .done      (done),
        .clr       (clr),
        .sel_width (sel_width),
        .pulse     (sqe_pulse)
    );

    // Pick the terminal count for the current phase.
    always_comb limit = sel_width ? LIM_WIDTH : LIM_DELAY;

    sqe_bit_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (bit_tick),
        .limit (limit),
        .done  (done)
    );

    AST_PULSE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sqe_pulse) |-> $past(allow)) else $error("pulse in wrong mode"); // R5
    AST_NO_PULSE_IN_RESET: assert property (@(posedge clk)
        $past(!rst_n) |-> !sqe_pulse) else $error("pulse after reset"); // R1
endmodule

// File: tb/tb_sqe_heartbeat_gen.sv
module tb_sqe_heartbeat_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DLO = 6, WLO = 5, DHI = 16, WHI = 15;
    // {speed_10, full_duplex, sqe_off, tick period[2:0], expect pulse}
    localparam int NV = 8;
    localparam logic [6:0] VEC [NV] = '{
        7'b100_001_1, 7'b100_011_1, 7'b100_010_1, 7'b000_001_0,
        7'b110_001_0, 7'b101_001_0, 7'b011_001_0, 7'b100_100_1 };

    logic clk = 0, rst_n = 0, bit_tick = 0, tx_en = 0;
    logic full_duplex = 0, speed_10 = 1, sqe_off = 0;
    logic pulse_lo, pulse_hi, last_tick;
    int checks = 0, fails = 0, tick_per = 1, tick_ph = 0;
    bit done_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sqe_heartbeat_gen #(.DELAY_BITS(DLO), .WIDTH_BITS(WLO)) dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .full_duplex(full_duplex), .speed_10(speed_10), .sqe_off(sqe_off),
        .sqe_pulse(pulse_lo));
    sqe_heartbeat_gen #(.DELAY_BITS(DHI), .WIDTH_BITS(WHI)) dut_max (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .full_duplex(full_duplex), .speed_10(speed_10), .sqe_off(sqe_off),
        .sqe_pulse(pulse_hi));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: set the tick for this edge, pass the edge, settle.
    task automatic step();
        bit_tick = (tick_ph == tick_per - 1);
        tick_ph  = bit_tick ? 0 : tick_ph + 1;
        last_tick = bit_tick;
        @(posedge clk); #1;
    endtask

    // Transmission of len cycles; returns after the edge that sees tx_en low.
    task automatic send_tx(input int len);
        tx_en = 1;
        for (int i = 0; i < len; i++) step();
        tx_en = 0;
        step();
    endtask

    // Measure delay and width in ticks on the chosen instance.
    task automatic measure(input bit sel, output bit seen, output int dly, output int wid);
        int pre = 0, hi = 0;
        bit rose = 0, fell = 0;
        logic p;
        dly = -1; wid = -1;
        for (int i = 0; i < 200 && !fell; i++) begin
            step();
            p = sel ? pulse_hi : pulse_lo;
            if (!rose) begin
                if (last_tick) pre++;
                if (p) begin rose = 1; dly = pre; end
            end else begin
                if (last_tick) hi++;
                if (!p) begin fell = 1; wid = hi; end
            end
        end
        seen = rose;
    endtask

    task automatic watch_quiet(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin step(); if (pulse_lo) hits++; end
        check(req, hits, 0);
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < 100 && !pulse_lo; i++) step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done_run) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        bit seen; int dly, wid; string rq;
        step(); step();
        check("R1 reset low", pulse_lo, 0);
        rst_n = 1;
        watch_quiet(40, "R11 ticks without transmission");

        // Table of mode and tick-spacing cases.
        for (int v = 0; v < NV; v++) begin
            speed_10 = VEC[v][6]; full_duplex = VEC[v][5]; sqe_off = VEC[v][4];
            tick_per = int'(VEC[v][3:1]); tick_ph = 0;
            send_tx(5);
            measure(0, seen, dly, wid);
            if (!speed_10) rq = "R5"; else if (full_duplex) rq = "R6";
            else if (sqe_off) rq = "R7"; else rq = (tick_per > 1) ? "R4" : "R2";
            check({rq, " pulse present"}, int'(seen), int'(VEC[v][0]));
            if (VEC[v][0]) begin
                check({rq, " R2 delay ticks"}, dly, DLO);
                check({rq, " R3 width ticks"}, wid, WLO);
            end
            for (int i = 0; i < 30; i++) step();
        end
        speed_10 = 1; full_duplex = 0; sqe_off = 0; tick_per = 1; tick_ph = 0;

        // Upper parameter bound.
        send_tx(3);
        measure(1, seen, dly, wid);
        check("R10 max delay", dly, DHI);
        check("R10 max width", wid, WHI);
        for (int i = 0; i < 10; i++) step();

        // New transmission during the delay.
        send_tx(4);
        step(); step(); step();
        tx_en = 1; step();
        check("R8 cancel in delay", pulse_lo, 0);
        step(); tx_en = 0; step();
        measure(0, seen, dly, wid);
        check("R8 full restart delay", dly, DLO);
        check("R8 restart width", wid, WLO);

        // New transmission during the pulse.
        send_tx(4); wait_pulse();
        check("R8 pulse reached", pulse_lo, 1);
        tx_en = 1; step();
        check("R8 cancel in pulse", pulse_lo, 0);
        step(); step(); tx_en = 0; step();
        measure(0, seen, dly, wid);
        check("R8 later transmission delay", dly, DLO);

        // Mode change during pulse and during delay.
        send_tx(4); wait_pulse();
        sqe_off = 1; step();
        check("R9 off cancels pulse", pulse_lo, 0);
        sqe_off = 0;
        watch_quiet(30, "R9 no resume after pulse cancel");
        send_tx(4); step(); step();
        full_duplex = 1; step(); full_duplex = 0;
        watch_quiet(30, "R9 no resume after delay cancel");
        send_tx(4); step(); step();
        speed_10 = 0; step(); speed_10 = 1;
        watch_quiet(30, "R9 speed change cancels");

        // Reset during the pulse.
        send_tx(4); wait_pulse();
        rst_n = 0; step();
        check("R1 reset clears pulse", pulse_lo, 0);
        rst_n = 1;
        watch_quiet(30, "R1 stays idle after reset");

        done_run = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule